// File: doc/BRIEF.md
# Palette Colour Table Loader

This block holds a 256-entry colour table with separate 8-bit red, green and blue arrays. Software loads it through two bus registers. A write to the index register picks the entry to fill. Each following write to the colour-map register stores one component byte, always in the order red, green, blue. After the blue byte the index moves on to the next entry by itself, so a whole table can be streamed in after a single index write.

Bus writes can be byte-sized or 32-bit. A 32-bit write is split into four component bytes, most significant byte first, and each byte advances the component phase. A 32-bit write can therefore finish one entry and start the next. A separate lookup port takes an 8-bit pixel index and returns the packed 24-bit colour one clock later. Any colour-map write raises a sticky redraw request, which the display side clears with an acknowledge pulse.

Top module: `palette_loader`

## Requirements
- R1: A write to offset 0x00 loads `bus_wdata[7:0]` as the current index and sets the component phase back to red, whatever the phase was before.
- R2: Successive component bytes written to offset 0x04 go to the red array, then green, then blue of the current index.
- R3: After a blue byte is stored, the index increments modulo 256 (255 wraps to 0) and the phase returns to red.
- R4: With `bus_word`=0 a colour-map write supplies one component taken from `bus_wdata[7:0]`. With `bus_word`=1 it supplies four components in the order bits 31:24, 23:16, 15:8, 7:0, and each one advances the phase and the index as in R2 and R3.
- R5: `bus_rdata` reads as zero for both register offsets.
- R6: Reset clears all 768 table bytes to zero, sets the index to 0 and the phase to red, and raises the redraw request.
- R7: Every colour-map write sets `redraw_req` on the next clock. `redraw_ack` clears it. If a write and an acknowledge arrive in the same cycle, the write wins.
- R8: `lut_rgb` presents {red[p], green[p], blue[p]} in bits 23:16, 15:8 and 7:0 one clock after `lut_idx`=p is sampled.
- R9: A lookup of an entry that is being written in the same cycle returns the value the entry held before that write.
- R10: Writes to any offset other than 0x00 and 0x04 change neither the table, the index, the phase nor the redraw request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_word | input | 1 | 1 = 32-bit write, 0 = byte write |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data (always zero) |
| lut_idx | input | 8 | Pixel index to look up |
| lut_rgb | output | 24 | Packed colour of the looked-up entry |
| redraw_req | output | 1 | Sticky request for a full redraw |
| redraw_ack | input | 1 | Clears the redraw request |

## Verification
The embedded properties assume the strobe and address are clean after reset. They also assume that index and colour-map writes never coincide, because only one address is presented per cycle. The bench keeps every input idle during reset. It changes inputs only on falling edges and drives each strobe for exactly one cycle, so each property sees whole, single-cycle transactions.

// File: rtl/palette_loader.sv
module palette_loader #(
  parameter int IDX_W     = 8,
  parameter int COMP_W    = 8,
  parameter int BUS_W     = 32,
  parameter int ADDR_W    = 5,
  parameter int OFS_INDEX = 0,
  parameter int OFS_CMAP  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]     bus_wdata,
  input  logic                 bus_word,
  input  logic                 bus_wr,
  output logic [BUS_W-1:0]     bus_rdata,
  input  logic [IDX_W-1:0]     lut_idx,
  output logic [3*COMP_W-1:0]  lut_rgb,
  output logic                 redraw_req,
  input  logic                 redraw_ack
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int LANES = BUS_W / COMP_W;

  logic [COMP_W-1:0] red_m [DEPTH];
  logic [COMP_W-1:0] grn_m [DEPTH];
  logic [COMP_W-1:0] blu_m [DEPTH];

  logic [IDX_W-1:0] idx_q;
  logic [1:0]       phase_q;
  logic             redraw_q;
  logic [3*COMP_W-1:0] rgb_q;

  logic idx_wr, cmap_wr;
  assign idx_wr  = bus_wr && (bus_addr == ADDR_W'(OFS_INDEX));
  assign cmap_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CMAP));

  logic [1:0]        ln_ph  [LANES+1];
  logic [IDX_W-1:0]  ln_ix  [LANES+1];
  logic [COMP_W-1:0] ln_val [LANES];
  logic              ln_en  [LANES];

  always_comb begin
    ln_ph[0] = phase_q;
    ln_ix[0] = idx_q;
    for (int k = 0; k < LANES; k++) begin
      ln_en[k]    = cmap_wr && (bus_word || (k == 0));
      ln_val[k]   = bus_word ? bus_wdata[BUS_W-1-k*COMP_W -: COMP_W] : bus_wdata[COMP_W-1:0];
      ln_ph[k+1]  = (ln_ph[k] == 2'd2) ? 2'd0 : ln_ph[k] + 2'd1;
      ln_ix[k+1]  = (ln_ph[k] == 2'd2) ? ln_ix[k] + 1'b1 : ln_ix[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        red_m[e] <= '0;
        grn_m[e] <= '0;
        blu_m[e] <= '0;
      end
      idx_q   <= '0;
      phase_q <= 2'd0;
    end else if (idx_wr) begin
      idx_q   <= bus_wdata[IDX_W-1:0];
      phase_q <= 2'd0;
    end else if (cmap_wr) begin
      for (int k = 0; k < LANES; k++) begin
        if (ln_en[k]) begin
          case (ln_ph[k])
            2'd0:    red_m[ln_ix[k]] <= ln_val[k];
            2'd1:    grn_m[ln_ix[k]] <= ln_val[k];
            default: blu_m[ln_ix[k]] <= ln_val[k];
          endcase
        end
      end
      phase_q <= bus_word ? ln_ph[LANES] : ln_ph[1];
      idx_q   <= bus_word ? ln_ix[LANES] : ln_ix[1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) redraw_q <= 1'b1;
    else if (cmap_wr) redraw_q <= 1'b1;
    else if (redraw_ack) redraw_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rgb_q <= '0;
    else rgb_q <= {red_m[lut_idx], grn_m[lut_idx], blu_m[lut_idx]};
  end

  assign lut_rgb    = rgb_q;
  assign redraw_req = redraw_q;
  assign bus_rdata  = '0;

  // R1
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wr |=> (phase_q == 2'd0) && (idx_q == $past(bus_wdata[IDX_W-1:0])));

  // R4
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmap_wr |=> phase_q == (($past(phase_q) == 2'd2) ? 2'd0 : $past(phase_q) + 2'd1));

  // R3
  idx_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmap_wr && !bus_word && phase_q == 2'd2) |=> idx_q == $past(idx_q) + 1'b1);

  // R2
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmap_wr && !bus_word && phase_q != 2'd2) |=> $stable(idx_q));

  // R7
  redraw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmap_wr |=> redraw_req);

  // R7
  redraw_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_ack && !cmap_wr) |=> !redraw_req);

  // R10
  other_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idx_wr && !cmap_wr) |=> $stable(idx_q) && $stable(phase_q));

endmodule

// File: tb/palette_loader_tb_top.sv
module palette_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_word = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  lut_idx = '0;
  logic [23:0] lut_rgb;
  logic        redraw_req;
  logic        redraw_ack = 1'b0;
  logic        lk_req = 1'b0;

  always #10 clk = ~clk;

  palette_loader dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_word(bus_word), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
    .lut_idx(lut_idx), .lut_rgb(lut_rgb), .redraw_req(redraw_req),
    .redraw_ack(redraw_ack)
  );

  int checks = 0, failures = 0;
  logic [7:0] m_r [256], m_g [256], m_b [256];
  logic [7:0] m_idx;
  int         m_ph;
  logic [23:0] sb_exp [$];
  string       sb_tag [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_comp(input logic [7:0] v);
    case (m_ph)
      0: m_r[m_idx] = v;
      1: m_g[m_idx] = v;
      default: m_b[m_idx] = v;
    endcase
    if (m_ph == 2) begin m_ph = 0; m_idx = m_idx + 8'd1; end
    else m_ph++;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic w);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic set_index(input logic [7:0] v);
    bus_write(5'h00, {24'h0, v}, 1'b0);
    m_idx = v; m_ph = 0;
  endtask

  task automatic put_byte(input logic [7:0] v);
    bus_write(5'h04, {24'hABCDEF, v}, 1'b0);
    model_comp(v);
  endtask

  task automatic put_word(input logic [31:0] v);
    bus_write(5'h04, v, 1'b1);
    for (int k = 3; k >= 0; k--) model_comp(v[k*8 +: 8]);
  endtask

  task automatic lookup(input logic [7:0] p, input string tag);
    @(negedge clk);
    lut_idx = p; lk_req = 1'b1;
    sb_exp.push_back({m_r[p], m_g[p], m_b[p]});
    sb_tag.push_back(tag);
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  initial begin
    forever begin
      logic v;
      @(posedge clk);
      v = lk_req;
      #5;
      if (v) begin
        logic [23:0] e;
        string t;
        e = sb_exp.pop_front();
        t = sb_tag.pop_front();
        chk(lut_rgb === e, t, {8'h0, lut_rgb}, {8'h0, e});
      end
    end
  end

  initial begin
    #(20 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int e = 0; e < 256; e++) begin m_r[e] = 0; m_g[e] = 0; m_b[e] = 0; end
    m_idx = 0; m_ph = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6: reset state
    chk(redraw_req === 1'b1, "R6 redraw after reset", {31'h0, redraw_req}, 32'h1);
    // R5
    chk(bus_rdata === 32'h0, "R5 rdata", bus_rdata, 32'h0);
    lookup(8'd0, "R6 entry0 cleared");
    lookup(8'd200, "R6 entry200 cleared");
    // R6: index 0 red phase after reset
    put_byte(8'h5A);
    lookup(8'd0, "R6 first byte to red[0]");

    // R1/R2: ordered R,G,B
    set_index(8'd10);
    put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
    lookup(8'd10, "R2 RGB order");
    lookup(8'd11, "R3 next untouched");
    // R3: auto-advance
    put_byte(8'h44);
    lookup(8'd11, "R3 auto increment");
    // R4: word from green phase
    put_word(32'hA1B2C3D4);
    lookup(8'd11, "R4 word completes entry");
    lookup(8'd12, "R4 word starts next entry");
    // R4: word from red phase
    set_index(8'd40);
    put_word(32'h01020304);
    lookup(8'd40, "R4 word msb first");
    lookup(8'd41, "R4 fourth byte");
    // R4: word from blue phase
    put_byte(8'h77);
    put_word(32'hE1E2E3E4);
    lookup(8'd41, "R4 word blue phase");
    lookup(8'd42, "R4 word fills next");
    // R3: wrap 255 -> 0
    set_index(8'd255);
    put_byte(8'hF1); put_byte(8'hF2); put_byte(8'hF3); put_byte(8'hF4);
    lookup(8'd255, "R3 entry255");
    lookup(8'd0, "R3 wrap to 0");
    // R1: index write mid-entry resets phase
    set_index(8'd5);
    put_byte(8'h99);
    set_index(8'd6);
    put_byte(8'h88);
    lookup(8'd5, "R1 partial entry5");
    lookup(8'd6, "R1 phase reset");

    // R7: ack clears, write sets
    @(negedge clk); redraw_ack = 1'b1; @(negedge clk); redraw_ack = 1'b0;
    chk(redraw_req === 1'b0, "R7 ack clears", {31'h0, redraw_req}, 32'h0);
    // R10: other offset ignored
    bus_write(5'h10, 32'h000000C7, 1'b0);
    bus_write(5'h08, 32'hFFFFFFFF, 1'b1);
    chk(redraw_req === 1'b0, "R10 no redraw", {31'h0, redraw_req}, 32'h0);
    put_byte(8'h3C);
    lookup(8'd6, "R10 index and phase kept");
    lookup(8'd199, "R10 entry199 untouched");
    chk(redraw_req === 1'b1, "R7 write sets", {31'h0, redraw_req}, 32'h1);
    // R7: simultaneous write and ack, write wins
    @(negedge clk); redraw_ack = 1'b1; @(negedge clk); redraw_ack = 1'b0;
    @(negedge clk);
    bus_addr = 5'h04; bus_wdata = 32'h5; bus_word = 1'b0; bus_wr = 1'b1; redraw_ack = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; redraw_ack = 1'b0;
    model_comp(8'h05);
    chk(redraw_req === 1'b1, "R7 write beats ack", {31'h0, redraw_req}, 32'h1);
    // R5 again after activity
    chk(bus_rdata === 32'h0, "R5 rdata after writes", bus_rdata, 32'h0);

    // R9: write and lookup same entry same cycle
    set_index(8'd70);
    @(negedge clk);
    bus_addr = 5'h04; bus_wdata = 32'h6B; bus_word = 1'b0; bus_wr = 1'b1;
    lut_idx = 8'd70; lk_req = 1'b1;
    sb_exp.push_back({m_r[70], m_g[70], m_b[70]});
    sb_tag.push_back("R9 old value");
    @(negedge clk);
    bus_wr = 1'b0; lk_req = 1'b0;
    model_comp(8'h6B);
    lookup(8'd70, "R9 new value next");
    // R8: back-to-back lookups, packing
    @(negedge clk);
    lut_idx = 8'd40; lk_req = 1'b1;
    sb_exp.push_back({m_r[40], m_g[40], m_b[40]}); sb_tag.push_back("R8 b2b first");
    @(negedge clk);
    lut_idx = 8'd11;
    sb_exp.push_back({m_r[11], m_g[11], m_b[11]}); sb_tag.push_back("R8 b2b second");
    @(negedge clk);
    lk_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(sb_exp.size() == 0, "R8 all lookups seen", sb_exp.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule